// File: doc/BRIEF.md
# First-Come First-Served Bus Arbiter

This block shares one bus among four requesters strictly in the order their requests arrive. No requester outranks another, and there is no priority that rotates. Each requester drives an active-low request line. The block answers on a matching active-low grant line, and grant n belongs only to request n. A common active-low enable gates all grants. While enable is high the grants are parked inactive, but arrivals are still recorded in order.

All inputs may be asynchronous to the clock. Every request line and the enable pass through a synchronizer chain before any decision is made. Each synchronized cycle, the block adds newly asserted requesters to the tail of an arrival queue and drops any queued requester whose line has gone inactive. The remaining entries keep their relative order. When several requests arrive in the same synchronized cycle, a free-running LFSR picks the order in which they join the queue. The queue head is granted and keeps the grant until it releases its request. Grants come from a register, so at most one is ever low. A handover always includes one cycle in which no grant is low.

Top module: `fcfs_arbiter`

## Requirements
- R1: After a synchronous active-high reset, all grant lines are high and the arrival queue is empty. A request held through reset is served as a fresh arrival once reset is released.
- R2: A lone request driven low (bit n of `req_n`) produces `grant_n[n]` low on the fourth rising edge after the request is applied. The grant is still high after the third edge. A grant is only ever low for a request that was seen, synchronized, as asserted.
- R3: Requests are served in the order they arrive. A requester that asserts while another holds the grant waits, and it is served before any requester that arrives after it.
- R4: When the holder drives its request high, its grant returns high on the third rising edge after the release. The next requester in the queue is granted one edge later, so exactly one cycle passes with all grants high.
- R5: At no time is more than one grant line low.
- R6: Requests that arrive in the same synchronized cycle receive exactly one grant, with no cycle where two grants are low. The other tied requesters are then served one after another as each holder releases, so every tied requester is served.
- R7: With `grant_en_n` high, all grants are high by the third edge after enable rises. Requests keep queueing while grants are disabled. When enable returns low, the queue head is granted on the third edge after enable falls.
- R8: A waiting requester that withdraws before it is granted leaves the queue. The requesters still waiting are served in their original order.
- R9: A request line held high is never granted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_n | input | NUM_REQ | Request lines, active low, may be asynchronous |
| grant_en_n | input | 1 | Common grant enable, active low, may be asynchronous |
| grant_n | output | NUM_REQ | Registered one-hot grant lines, active low |

## Verification
Counting rising edges from the cycle an input changes, the timing is as follows. A new grant is due on edge four. A grant returns high on edge three after its holder releases, and the successor is granted on edge four. A change of enable shows on the grant lines on edge three. The bench drives inputs on falling edges, records the current edge count, and queues every expected grant pattern against the exact edge at which it is due. It also queues the still-inactive pattern one edge earlier, so a result that comes early is caught as well as one that comes late. For ties, the expectation accepts any single member of the tied set, and the bench's later expectations follow the requester that actually won.

// File: rtl/fcfs_arb_pkg.sv
package fcfs_arb_pkg;

   typedef enum logic {
      TIE_LFSR  = 1'b0,
      TIE_FIXED = 1'b1
   } tie_mode_e;

   function automatic int unsigned idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/fcfs_sync.sv
module fcfs_sync #(
   parameter int unsigned WIDTH  = 5,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("fcfs_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (rst) stage_q[s] <= '0;
            else     stage_q[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (rst) stage_q[s] <= '0;
            else     stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign q = stage_q[STAGES-1];

endmodule

// File: rtl/fcfs_lfsr.sv
module fcfs_lfsr #(
   parameter int unsigned     W    = 4,
   parameter logic [W-1:0]    TAPS = 4'b1100,
   parameter logic [W-1:0]    SEED = 4'b0001
) (
   input  logic         clk,
   input  logic         rst,
   output logic [W-1:0] state
);

   if (SEED == '0) begin : g_bad_seed
      $error("fcfs_lfsr: SEED must be non-zero");
   end
   if (W < 2) begin : g_bad_width
      $error("fcfs_lfsr: W must be at least 2");
   end

   logic [W-1:0] state_q;

   always_ff @(posedge clk) begin
      if (rst) state_q <= SEED;
      else     state_q <= {state_q[W-2:0], ^(state_q & TAPS)};
   end

   assign state = state_q;

endmodule

// File: rtl/fcfs_tiebreak.sv
module fcfs_tiebreak
   import fcfs_arb_pkg::*;
#(
   parameter int unsigned N      = 4,
   parameter int unsigned LFSR_W = 4,
   parameter tie_mode_e   MODE   = TIE_LFSR,
   localparam int unsigned IW    = idx_width(N)
) (
   input  logic [LFSR_W-1:0] state,
   output logic [IW-1:0]     start
);

   if (MODE == TIE_LFSR) begin : g_lfsr
      logic [31:0] state_w;
      assign state_w = 32'(state);
      assign start   = IW'(state_w % N);
   end else begin : g_fixed
      logic unused_state;
      assign unused_state = ^state;
      assign start        = '0;
   end

endmodule

// File: rtl/fcfs_queue.sv
module fcfs_queue
   import fcfs_arb_pkg::*;
#(
   parameter int unsigned N = 4,
   localparam int unsigned IW = idx_width(N),
   localparam int unsigned CW = $clog2(N + 1)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [N-1:0]  req_s,
   input  logic [IW-1:0] start,
   output logic [IW-1:0] head_idx,
   output logic          head_vld
);

   logic [IW-1:0] slot_q [N];
   logic [IW-1:0] slot_d [N];
   logic [CW-1:0] cnt_q, cnt_d;
   logic [N-1:0]  member;
   logic [N-1:0]  arrive;

   always_comb begin
      member = '0;
      for (int i = 0; i < N; i++) begin
         if (i < int'(cnt_q)) member[slot_q[i]] = 1'b1;
      end
      arrive = req_s & ~member;
   end

   always_comb begin
      int unsigned keep;
      int unsigned idx;
      keep = 0;
      for (int i = 0; i < N; i++) slot_d[i] = '0;
      for (int i = 0; i < N; i++) begin
         if ((i < int'(cnt_q)) && req_s[slot_q[i]]) begin
            slot_d[keep] = slot_q[i];
            keep = keep + 1;
         end
      end
      for (int k = 0; k < N; k++) begin
         idx = int'(start) + k;
         if (idx >= N) idx = idx - N;
         if (arrive[idx]) begin
            slot_d[keep] = IW'(idx);
            keep = keep + 1;
         end
      end
      cnt_d = CW'(keep);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
         for (int i = 0; i < N; i++) slot_q[i] <= '0;
      end else begin
         cnt_q <= cnt_d;
         for (int i = 0; i < N; i++) slot_q[i] <= slot_d[i];
      end
   end

   assign head_vld = (cnt_q != '0);
   assign head_idx = slot_q[0];

endmodule

// File: rtl/fcfs_arbiter.sv
module fcfs_arbiter
   import fcfs_arb_pkg::*;
#(
   parameter int unsigned          NUM_REQ     = 4,
   parameter int unsigned          SYNC_STAGES = 2,
   parameter int unsigned          LFSR_W      = 4,
   parameter logic [LFSR_W-1:0]    LFSR_TAPS   = 4'b1100,
   parameter logic [LFSR_W-1:0]    LFSR_SEED   = 4'b0001,
   parameter tie_mode_e            TIE_MODE    = TIE_LFSR
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [NUM_REQ-1:0] req_n,
   input  logic               grant_en_n,
   output logic [NUM_REQ-1:0] grant_n
);

   localparam int unsigned IW = idx_width(NUM_REQ);

   if (NUM_REQ < 2) begin : g_bad_num
      $error("fcfs_arbiter: NUM_REQ must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("fcfs_arbiter: SYNC_STAGES must be at least 2");
   end
   if ((2 ** LFSR_W) < NUM_REQ) begin : g_bad_lfsr
      $error("fcfs_arbiter: LFSR too narrow to pick among requesters");
   end

   logic [NUM_REQ-1:0] req_s;
   logic               en_s;
   logic [LFSR_W-1:0]  lfsr_state;
   logic [IW-1:0]      tie_start;
   logic [IW-1:0]      head_idx;
   logic               head_vld;
   logic [NUM_REQ-1:0] grant_q, grant_d;

   fcfs_sync #(
      .WIDTH  (NUM_REQ + 1),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk (clk),
      .rst (rst),
      .d   ({~grant_en_n, ~req_n}),
      .q   ({en_s, req_s})
   );

   fcfs_lfsr #(
      .W    (LFSR_W),
      .TAPS (LFSR_TAPS),
      .SEED (LFSR_SEED)
   ) u_lfsr (
      .clk   (clk),
      .rst   (rst),
      .state (lfsr_state)
   );

   fcfs_tiebreak #(
      .N      (NUM_REQ),
      .LFSR_W (LFSR_W),
      .MODE   (TIE_MODE)
   ) u_tie (
      .state (lfsr_state),
      .start (tie_start)
   );

   fcfs_queue #(
      .N (NUM_REQ)
   ) u_queue (
      .clk      (clk),
      .rst      (rst),
      .req_s    (req_s),
      .start    (tie_start),
      .head_idx (head_idx),
      .head_vld (head_vld)
   );

   always_comb begin
      grant_d = '0;
      if (!en_s) begin
         grant_d = '0;
      end else if (|grant_q) begin
         grant_d = (|(grant_q & req_s)) ? grant_q : '0;
      end else if (head_vld && req_s[head_idx]) begin
         grant_d[head_idx] = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) grant_q <= '0;
      else     grant_q <= grant_d;
   end

   assign grant_n = ~grant_q;

endmodule

// File: rtl/fcfs_arbiter_chk.sv
module fcfs_arbiter_chk #(
   parameter int unsigned N = 4
) (
   input logic         clk,
   input logic         rst,
   input logic [N-1:0] req_s,
   input logic         en_s,
   input logic [N-1:0] grant_n
);

   logic rst_d;
   always_ff @(posedge clk) rst_d <= rst;

   // R1: the edge following a reset cycle leaves every grant high
   always @(posedge clk) begin
      if (rst_d === 1'b1) begin
         a_r1_reset_idle: assert (grant_n == '1)
            else $error("R1 grant low after reset");
      end
   end

   a_r5_one_grant: assert property (@(posedge clk) disable iff (rst)
      $countones(~grant_n) <= 1);

   a_r4_handover_gap: assert property (@(posedge clk) disable iff (rst)
      (grant_n != '1 && $past(grant_n) != '1) |-> grant_n == $past(grant_n));

   a_r7_enable_off: assert property (@(posedge clk) disable iff (rst)
      !$past(en_s) |-> grant_n == '1);

   a_r2_grant_needs_request: assert property (@(posedge clk) disable iff (rst)
      ((~grant_n) & ~$past(req_s)) == '0);

endmodule

bind fcfs_arbiter fcfs_arbiter_chk #(.N(NUM_REQ)) u_chk (
   .clk     (clk),
   .rst     (rst),
   .req_s   (req_s),
   .en_s    (en_s),
   .grant_n (grant_n)
);

// File: tb/fcfs_arbiter_tb.sv
`timescale 1ns/1ps
module fcfs_arbiter_tb;

   typedef struct {
      int         due;
      bit         any;
      logic [3:0] val;
      string      tag;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [3:0] req_n = 4'hF;
   logic       grant_en_n = 1'b0;
   logic [3:0] grant_n;

   int   cyc = 0;
   int   now = 0;
   int   total = 0;
   int   bad = 0;
   logic [3:0] last_pick = 4'h0;
   exp_t sb[$];

   fcfs_arbiter u_dut (
      .clk        (clk),
      .rst        (rst),
      .req_n      (req_n),
      .grant_en_n (grant_en_n),
      .grant_n    (grant_n)
   );

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   // monitor: pop every expectation due at this edge count
   always @(negedge clk) begin
      for (int i = sb.size() - 1; i >= 0; i--) begin
         if (sb[i].due == cyc) begin
            bit ok;
            total++;
            if (sb[i].any) begin
               ok = ($countones(~grant_n) == 1) && (((~grant_n) & ~sb[i].val) == 4'h0);
               if (ok) last_pick = ~grant_n;
            end else begin
               ok = (grant_n === sb[i].val);
            end
            if (!ok) begin
               bad++;
               $display("FAIL %s cycle=%0d actual=%b expected=%b%s", sb[i].tag, cyc,
                        grant_n, sb[i].val, sb[i].any ? " (one of active mask)" : "");
            end
            sb.delete(i);
         end
      end
   end

   task automatic expect_at(input int off, input bit any, input logic [3:0] v, input string tag);
      exp_t e;
      e.due = now + off;
      e.any = any;
      e.val = v;
      e.tag = tag;
      sb.push_back(e);
   endtask

   task automatic act(input logic [3:0] rq, input logic en);
      @(negedge clk);
      req_n      = rq;
      grant_en_n = en;
      now        = cyc;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic tie_run(input logic [3:0] act_mask, input string tag);
      logic [3:0] left;
      logic [3:0] rq;
      logic [3:0] pick;
      left = act_mask;
      rq   = ~act_mask;
      act(rq, 1'b0);
      expect_at(3, 1'b0, 4'hF, tag);
      expect_at(4, 1'b1, left, tag);
      idle(6);
      while (left != 4'h0) begin
         pick = last_pick & left;
         if (pick == 4'h0) break;
         left = left & ~pick;
         rq   = rq | pick;
         act(rq, 1'b0);
         expect_at(3, 1'b0, 4'hF, tag);
         if (left != 4'h0) expect_at(4, 1'b1, left, tag);
         idle(6);
      end
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      idle(3);
      rst = 1'b0;
      now = cyc;
      expect_at(1, 1'b0, 4'hF, "R1 reset state");
      idle(3);

      // R2 / R9: lone request 2; line 1 stays high throughout
      act(4'b1011, 1'b0);
      expect_at(3, 1'b0, 4'hF, "R2 not early");
      expect_at(4, 1'b0, 4'b1011, "R2 lone grant");
      idle(6);

      // R3: request 0 then 3 queue behind holder 2
      act(4'b1010, 1'b0);
      idle(2);
      act(4'b0010, 1'b0);
      expect_at(5, 1'b0, 4'b1011, "R3 holder kept, R9 line 1 idle");
      idle(6);
      act(4'b0110, 1'b0);
      expect_at(2, 1'b0, 4'b1011, "R4 holder until release seen");
      expect_at(3, 1'b0, 4'hF, "R4 handover gap");
      expect_at(4, 1'b0, 4'b1110, "R3 earliest waiter");
      idle(6);
      act(4'b0111, 1'b0);
      expect_at(3, 1'b0, 4'hF, "R4 gap");
      expect_at(4, 1'b0, 4'b0111, "R3 next waiter");
      idle(6);
      act(4'hF, 1'b0);
      expect_at(4, 1'b0, 4'hF, "R4 all released");
      idle(6);

      // R6: simultaneous arrivals
      tie_run(4'b1001, "R6 two-way tie");
      tie_run(4'b0111, "R6 three-way tie");
      tie_run(4'b1111, "R6 four-way tie");

      // R7: enable gating
      act(4'b1110, 1'b0);
      expect_at(4, 1'b0, 4'b1110, "R7 granted while enabled");
      idle(6);
      act(4'b1110, 1'b1);
      expect_at(2, 1'b0, 4'b1110, "R7 disable not early");
      expect_at(3, 1'b0, 4'hF, "R7 disabled");
      idle(5);
      act(4'b1110, 1'b0);
      expect_at(2, 1'b0, 4'hF, "R7 enable not early");
      expect_at(3, 1'b0, 4'b1110, "R7 re-enabled");
      idle(5);
      act(4'b1110, 1'b1);
      idle(4);
      act(4'b1100, 1'b1);
      expect_at(6, 1'b0, 4'hF, "R7 queued while disabled");
      idle(6);
      act(4'b1101, 1'b1);
      idle(6);
      act(4'b1101, 1'b0);
      expect_at(3, 1'b0, 4'b1101, "R7 head granted on enable");
      idle(6);
      act(4'hF, 1'b0);
      idle(6);

      // R8: waiting requester withdraws
      act(4'b1110, 1'b0);
      idle(6);
      act(4'b1100, 1'b0);
      idle(2);
      act(4'b1000, 1'b0);
      idle(2);
      act(4'b0000, 1'b0);
      idle(6);
      act(4'b0100, 1'b0);
      expect_at(6, 1'b0, 4'b1110, "R8 withdraw leaves holder");
      idle(6);
      act(4'b0101, 1'b0);
      expect_at(4, 1'b0, 4'b1101, "R8 order kept");
      idle(6);
      act(4'b0111, 1'b0);
      expect_at(4, 1'b0, 4'b0111, "R8 withdrawn skipped");
      idle(6);
      act(4'hF, 1'b0);
      idle(6);

      // R1: reset in the middle of a grant
      act(4'b1110, 1'b0);
      expect_at(4, 1'b0, 4'b1110, "R2 grant before reset");
      idle(6);
      @(negedge clk);
      rst = 1'b1;
      now = cyc;
      expect_at(1, 1'b0, 4'hF, "R1 reset clears grant");
      idle(2);
      @(negedge clk);
      rst = 1'b0;
      now = cyc;
      expect_at(3, 1'b0, 4'hF, "R1 fresh arrival not early");
      expect_at(4, 1'b0, 4'b1110, "R1 fresh arrival granted");
      idle(8);

      if (sb.size() != 0) begin
         total++;
         bad++;
         $display("FAIL R1 pending expectations actual=%0d expected=0", sb.size());
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule